// File: doc/BRIEF.md
# Two-Pulse Launch/Capture Clock Burst Generator

This block feeds a clock to the input/output port registers and the internal flops of a circuit under test. A select pin picks the source: the moderate-rate test clock, or a fast on-chip clock used for speed characterization. The output stays low until a trigger arrives. The trigger is a strobe two test-clock cycles wide. When it arrives, the block sends exactly two full pulses of the chosen clock, which gives one launch edge and one capture edge at the rate of that clock.

The trigger is first registered in the test-clock domain. A chain of flip-flops clocked by the selected clock then synchronizes it. An edge detector and a short shift chain turn it into an enable that lasts exactly two selected-clock periods. A gating stage closes the enable into a latch while the selected clock is low, then ANDs it with that clock, so only whole pulses reach the output. Each strobe is acted on once, on its rising edge. A new burst needs the trigger to go low for at least one test-clock cycle first.

The pins are all plain control and clock pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_clk_gen`

## Requirements
- R1: With `sel_fast` = 0 the burst pulses come from `tclk`: the two rising edges of one burst are one `tclk` period apart. With `sel_fast` = 1 they come from `fclk` and are one `fclk` period apart.
- R2: While `rst_n` is low, and after reset until a trigger arrives, `clk_out` stays low and shows no rising edge.
- R3: A trigger strobe two `tclk` cycles wide gives exactly two rising edges on `clk_out` when the test clock is selected.
- R4: A trigger strobe two `tclk` cycles wide gives exactly two rising edges on `clk_out` when the fast clock is selected.
- R5: Every pulse on `clk_out` is a whole pulse of the source clock. Its high time equals the source clock's high time, and `clk_out` is low between bursts.
- R6: A trigger held high for many cycles gives one burst only, with two rising edges in total.
- R7: Two strobes separated by one low `tclk` cycle give two bursts, with four rising edges in total.
- R8: `sel_fast` may change only while no burst is in progress. The first burst after a change uses the newly selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Moderate-rate test clock; also the clock of the trigger domain |
| fclk | input | 1 | Fast on-chip clock used for speed characterization |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_fast | input | 1 | Source select: 0 = test clock, 1 = fast clock |
| trig | input | 1 | Burst request, a strobe two `tclk` cycles wide |
| clk_out | output | 1 | Gated launch/capture clock: low when idle, two pulses per burst |

## Verification
Two things can happen in adjacent selected-clock cycles: the enable window of one burst is closing while the edge detector sees the rising edge of the next strobe. The bench provokes this by sending a second strobe after only one low `tclk` cycle, with each source. It expects four rising edges and checks that each pulse keeps the full high time of the source. Source switching is exercised by alternating the select between bursts. The spacing of the two captured rising edges must then match the period of the newly chosen clock.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_PULSES      = 2;

  typedef enum logic {
    SRC_TEST = 1'b0,
    SRC_FAST = 1'b1
  } clk_src_e;
endpackage

// File: rtl/burst_launch.sv
module burst_launch (
  input  logic tclk,
  input  logic rst_n,
  input  logic trig_i,
  output logic strobe_o
);
  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) strobe_o <= 1'b0;
    else        strobe_o <= trig_i;
  end
endmodule

// File: rtl/burst_sync.sv
module burst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/burst_window.sv
module burst_window #(
  parameter int unsigned PULSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic en_o
);
  localparam int unsigned CW = $clog2(PULSES + 1) + 1;

  logic              level_d;
  logic [PULSES-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_d <= 1'b0;
      win[0]  <= 1'b0;
    end else begin
      level_d <= level_i;
      win[0]  <= level_i & ~level_d;
    end
  end

  generate
    for (genvar i = 1; i < PULSES; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win[i] <= 1'b0;
        else        win[i] <= win[i-1];
      end
    end
  endgenerate

  assign en_o = |win;

  // checker: length of each enable run
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (en_o) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  p_run_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_o |-> (run_cnt < CW'(PULSES)));

  p_run_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> (run_cnt == CW'(PULSES)));
endmodule

// File: rtl/burst_gate.sv
module burst_gate (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o
);
  logic en_lat;

  always_latch begin
    if (!rst_n)     en_lat = 1'b0;
    else if (!clk_i) en_lat = en_i;
  end

  assign clk_o = clk_i & en_lat;

  // the latch must hold what the enable flop showed just before the edge
  p_lat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_lat == en_i);
endmodule

// File: rtl/burst_clk_gen.sv
module burst_clk_gen
  import burst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned PULSES      = DEF_PULSES
) (
  input  logic tclk,
  input  logic fclk,
  input  logic rst_n,
  input  logic sel_fast,
  input  logic trig,
  output logic clk_out
);
  clk_src_e src;
  logic     src_clk;
  logic     strobe;
  logic     strobe_sync;
  logic     gate_en;

  assign src     = clk_src_e'(sel_fast);
  assign src_clk = (src == SRC_FAST) ? fclk : tclk;

  burst_launch u_launch (
    .tclk     (tclk),
    .rst_n    (rst_n),
    .trig_i   (trig),
    .strobe_o (strobe)
  );

  burst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d_i   (strobe),
    .q_o   (strobe_sync)
  );

  burst_window #(.PULSES(PULSES)) u_window (
    .clk     (src_clk),
    .rst_n   (rst_n),
    .level_i (strobe_sync),
    .en_o    (gate_en)
  );

  burst_gate u_gate (
    .clk_i (src_clk),
    .rst_n (rst_n),
    .en_i  (gate_en),
    .clk_o (clk_out)
  );

  // R8: the source select must not move while a burst is running
  p_sel_stable_r8: assert property (@(posedge tclk) disable iff (!rst_n)
    gate_en |-> $stable(sel_fast));

  // R2: nothing leaves the block while the trigger path is quiet
  p_quiet_idle_r2: assert property (@(posedge tclk) disable iff (!rst_n)
    (!strobe && !$past(strobe) && !strobe_sync && !gate_en) |-> !clk_out);
endmodule

// File: tb/sim_burst_clk_gen.sv
`timescale 1ns/1ps
module sim_burst_clk_gen;
  localparam real TPER = 20.0;
  localparam real FPER = 7.0;

  logic tclk = 1'b0;
  logic fclk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_fast = 1'b0;
  logic trig = 1'b0;
  logic clk_out;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  int falls = 0;
  real rise_t [8];
  real fall_t [8];

  always #(TPER/2.0) tclk = ~tclk;
  always #(FPER/2.0) fclk = ~fclk;

  burst_clk_gen u0 (
    .tclk     (tclk),
    .fclk     (fclk),
    .rst_n    (rst_n),
    .sel_fast (sel_fast),
    .trig     (trig),
    .clk_out  (clk_out)
  );

  always @(posedge clk_out) begin
    if (edges < 8) rise_t[edges] = $realtime;
    edges++;
  end
  always @(negedge clk_out) begin
    if (falls < 8) fall_t[falls] = $realtime;
    falls++;
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic clear_counts();
    @(negedge tclk);
    edges = 0;
    falls = 0;
  endtask

  task automatic strobe(input int hi);
    @(negedge tclk);
    trig = 1'b1;
    repeat (hi) @(negedge tclk);
    trig = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge tclk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge tclk);
    chk(clk_out == 1'b0, "R2 level in reset", real'(clk_out), 0.0);
    chk(edges == 0, "R2 edges in reset", real'(edges), 0.0);
    rst_n = 1'b1;
    repeat (20) @(negedge tclk);
    chk(edges == 0, "R2 edges idle after reset", real'(edges), 0.0);
  endtask

  task automatic t_single(input bit fast);
    real per;
    per = fast ? FPER : TPER;
    sel_fast = fast;
    repeat (5) @(negedge tclk);
    clear_counts();
    strobe(2);
    settle();
    if (fast) chk(edges == 2, "R4 two edges fast", real'(edges), 2.0);
    else      chk(edges == 2, "R3 two edges test", real'(edges), 2.0);
    chk(near(rise_t[1] - rise_t[0], per), "R1 edge spacing", rise_t[1] - rise_t[0], per);
    chk(near(fall_t[0] - rise_t[0], per/2.0), "R5 pulse 1 width", fall_t[0] - rise_t[0], per/2.0);
    chk(near(fall_t[1] - rise_t[1], per/2.0), "R5 pulse 2 width", fall_t[1] - rise_t[1], per/2.0);
    chk(clk_out == 1'b0, "R5 low after burst", real'(clk_out), 0.0);
  endtask

  task automatic t_held(input bit fast);
    sel_fast = fast;
    repeat (5) @(negedge tclk);
    clear_counts();
    strobe(25);
    settle();
    chk(edges == 2, "R6 held trigger one burst", real'(edges), 2.0);
  endtask

  task automatic t_rearm(input bit fast);
    real per;
    per = fast ? FPER : TPER;
    sel_fast = fast;
    repeat (5) @(negedge tclk);
    clear_counts();
    strobe(2);
    @(negedge tclk);
    trig = 1'b1;
    @(negedge tclk);
    @(negedge tclk);
    trig = 1'b0;
    settle();
    chk(edges == 4, "R7 rearm four edges", real'(edges), 4.0);
    chk(near(fall_t[2] - rise_t[2], per/2.0), "R7 second burst width", fall_t[2] - rise_t[2], per/2.0);
  endtask

  task automatic t_idle();
    clear_counts();
    repeat (40) @(negedge tclk);
    chk(edges == 0, "R5 no edges between bursts", real'(edges), 0.0);
  endtask

  task automatic t_switch();
    t_single(1'b0);
    t_single(1'b1);
    clear_counts();
    sel_fast = 1'b0;
    repeat (5) @(negedge tclk);
    clear_counts();
    strobe(2);
    settle();
    chk(near(rise_t[1] - rise_t[0], TPER), "R8 source after switch back", rise_t[1] - rise_t[0], TPER);
  endtask

  initial begin
    #(TPER * 200000.0);
    failures++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_single(1'b0);
    t_single(1'b1);
    t_idle();
    t_held(1'b0);
    t_held(1'b1);
    t_rearm(1'b0);
    t_rearm(1'b1);
    t_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule